// File: doc/BRIEF.md
# Three-Channel Timer Bus Front End

This block sits between an 8-bit processor bus and three timer channels whose counting logic is kept elsewhere. A two-bit address picks one of the three channel data ports or the control port. A control write sets, for the channel it names, the counting mode, a decimal (BCD) flag and the byte format used to move the 16-bit count across the 8-bit bus. Data writes are then gathered byte by byte into a full count, which is handed to the channel with a one-cycle load strobe. Data reads return the channel's live count, or a frozen copy of it, one byte per access in the same format.

A control write whose format field is zero does not reprogram the channel. It is a snapshot command: it copies the channel's current count into a holding register while the channel keeps counting, and later reads return the copy until the read sequence completes. Chip select, read and write are synchronous, active-high strobes sampled on the rising clock edge. Read data is registered and appears in the cycle after the read strobe.

Top module: `tmr_bus_if`

## Requirements
- R1: A write to address 3 with bits 7:6 equal to 0, 1 or 2 and bits 5:4 non-zero stores bits 3:1 as that channel's mode and bit 0 as its BCD flag, visible on mode_o and bcd_o from the next cycle. Other channels keep their settings. Bits 7:6 equal to 3 change nothing.
- R2: With format 01 (low byte only), each data write completes a load: ld_stb for that channel is high for exactly the next cycle, with ld_val equal to {8'h00, byte}.
- R3: With format 10 (high byte only), each data write completes a load with ld_val equal to {byte, 8'h00}.
- R4: With format 11, the first data write produces no load strobe. The second produces a one-cycle strobe with ld_val equal to {second byte, first byte}.
- R5: A data read presents its byte on rdata in the next cycle. Format 01 returns bits 7:0, format 10 returns bits 15:8, and format 11 alternates between the low byte and the high byte, starting with the low byte.
- R6: A control write with bits 5:4 equal to 00 captures the selected channel's live count at that clock edge. Reads then return the captured value, however the live count moves.
- R7: The captured value is released once the read sequence of the channel's format completes (one read for formats 01 and 10, two reads for 11). Later reads follow the live count.
- R8: A snapshot command to a channel that already holds an unread snapshot has no effect.
- R9: A control write that reprograms a channel returns both its write and read byte pointers to the low byte and discards any held snapshot.
- R10: A read of address 3 returns 8'h00 and advances no channel's read pointer.
- R11: When read and write strobes are both high in one cycle, only the write acts. rdata keeps its value and no read pointer moves.
- R12: After reset, every channel has mode 0, binary counting and format 11, with both pointers on the low byte; ld_stb and rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| live_cnt | input | 48 | Live counts, channel i at bits 16*i+15:16*i |
| ld_val | output | 48 | Assembled count per channel, same packing |
| ld_stb | output | 3 | One-cycle load strobe per channel |
| mode_o | output | 9 | Mode per channel, channel i at bits 3*i+2:3*i |
| bcd_o | output | 3 | BCD counting flag per channel |

## Verification
The two functions that meet in a single cycle are the snapshot capture and the channel's own count update. The bench changes a live count at the same clock edge that samples the snapshot command, then changes it again on the following cycle. It expects the frozen bytes to equal the value present at the capture edge and to match neither the earlier nor the later value. A second case drives read and write strobes together, and the bench judges it by an unchanged rdata and by which byte the next read returns.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    FMT_SNAP = 2'b00,
    FMT_LO   = 2'b01,
    FMT_HI   = 2'b10,
    FMT_BOTH = 2'b11
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [2:0] mode;
    logic       bcd;
  } chan_cfg_t;

  localparam logic [1:0] CTRL_ADDR = 2'b11;

  localparam chan_cfg_t CFG_RESET = '{fmt: FMT_BOTH, mode: 3'd0, bcd: 1'b0};

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
  parameter int NCH = 3
) (
  input  logic           cs,
  input  logic           rd,
  input  logic           wr,
  input  logic [1:0]     addr,
  input  logic [1:0]     cw_sel,
  input  logic [1:0]     cw_fmt,
  output logic [NCH-1:0] cfg_stb,
  output logic [NCH-1:0] snap_stb,
  output logic [NCH-1:0] dwr_stb,
  output logic [NCH-1:0] drd_stb,
  output logic           rd_take
);
  import tmr_pkg::*;

  logic wr_ok;
  logic ctl_wr;

  assign wr_ok   = cs & wr;
  assign rd_take = cs & rd & ~wr;
  assign ctl_wr  = wr_ok & (addr == CTRL_ADDR);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign dwr_stb[i]  = wr_ok   & (addr == 2'(i));
    assign drd_stb[i]  = rd_take & (addr == 2'(i));
    assign cfg_stb[i]  = ctl_wr  & (cw_sel == 2'(i)) & (cw_fmt != FMT_SNAP);
    assign snap_stb[i] = ctl_wr  & (cw_sel == 2'(i)) & (cw_fmt == FMT_SNAP);
  end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_stb,
  input  logic          snap_stb,
  input  logic          dwr_stb,
  input  logic          drd_stb,
  input  logic [BW-1:0] wbyte,
  input  logic [2*BW-1:0] live,
  output logic [BW-1:0] rd_byte,
  output logic [2*BW-1:0] ld_val,
  output logic          ld_stb,
  output logic [2:0]    mode,
  output logic          bcd
);
  import tmr_pkg::*;

  localparam int CW = 2 * BW;

  chan_cfg_t     cfg_q, cfg_d;
  logic          wptr_q, wptr_d;
  logic          rptr_q, rptr_d;
  logic          held_q, held_d;
  logic [CW-1:0] snap_q, snap_d;
  logic [BW-1:0] lo_q, lo_d;
  logic [CW-1:0] ldv_q, ldv_d;
  logic          lds_q, lds_d;

  logic [CW-1:0] src;
  logic          rd_last;

  assign src     = held_q ? snap_q : live;
  assign rd_last = (cfg_q.fmt != FMT_BOTH) | rptr_q;

  always_comb begin
    unique case (cfg_q.fmt)
      FMT_HI:   rd_byte = src[CW-1:BW];
      FMT_BOTH: rd_byte = rptr_q ? src[CW-1:BW] : src[BW-1:0];
      default:  rd_byte = src[BW-1:0];
    endcase
  end

  always_comb begin
    cfg_d  = cfg_q;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    held_d = held_q;
    snap_d = snap_q;
    lo_d   = lo_q;
    ldv_d  = ldv_q;
    lds_d  = 1'b0;

    if (cfg_stb) begin
      cfg_d.fmt  = fmt_e'(wbyte[5:4]);
      cfg_d.mode = wbyte[3:1];
      cfg_d.bcd  = wbyte[0];
      wptr_d     = 1'b0;
      rptr_d     = 1'b0;
      held_d     = 1'b0;
    end else if (snap_stb) begin
      if (!held_q) begin
        held_d = 1'b1;
        snap_d = live;
      end
    end

    if (dwr_stb) begin
      unique case (cfg_q.fmt)
        FMT_LO: begin
          ldv_d = {{BW{1'b0}}, wbyte};
          lds_d = 1'b1;
        end
        FMT_HI: begin
          ldv_d = {wbyte, {BW{1'b0}}};
          lds_d = 1'b1;
        end
        default: begin
          if (wptr_q) begin
            ldv_d  = {wbyte, lo_q};
            lds_d  = 1'b1;
            wptr_d = 1'b0;
          end else begin
            lo_d   = wbyte;
            wptr_d = 1'b1;
          end
        end
      endcase
    end

    if (drd_stb) begin
      rptr_d = (cfg_q.fmt == FMT_BOTH) ? ~rptr_q : 1'b0;
      if (rd_last) held_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      wptr_q <= 1'b0;
      rptr_q <= 1'b0;
      held_q <= 1'b0;
      snap_q <= '0;
      lo_q   <= '0;
      ldv_q  <= '0;
      lds_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      held_q <= held_d;
      snap_q <= snap_d;
      lo_q   <= lo_d;
      ldv_q  <= ldv_d;
      lds_q  <= lds_d;
    end
  end

  assign ld_val = ldv_q;
  assign ld_stb = lds_q;
  assign mode   = cfg_q.mode;
  assign bcd    = cfg_q.bcd;

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux #(
  parameter int NCH = 3,
  parameter int BW  = 8
) (
  input  logic [1:0]        addr,
  input  logic [NCH*BW-1:0] bytes,
  output logic [BW-1:0]     sel_byte
);
  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == 2'(i)) sel_byte = bytes[i*BW +: BW];
    end
  end

endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if #(
  parameter int NCH = 3,
  parameter int BW  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic                rd,
  input  logic                wr,
  input  logic [1:0]          addr,
  input  logic [BW-1:0]       wdata,
  output logic [BW-1:0]       rdata,
  input  logic [NCH*2*BW-1:0] live_cnt,
  output logic [NCH*2*BW-1:0] ld_val,
  output logic [NCH-1:0]      ld_stb,
  output logic [NCH*3-1:0]    mode_o,
  output logic [NCH-1:0]      bcd_o
);
  localparam int CW = 2 * BW;

  logic rs_a_q, rs_b_q;
  logic rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a_q <= 1'b0;
      rs_b_q <= 1'b0;
    end else begin
      rs_a_q <= 1'b1;
      rs_b_q <= rs_a_q;
    end
  end
  assign rst_i_n = rs_b_q;

  logic [NCH-1:0]    cfg_stb, snap_stb, dwr_stb, drd_stb;
  logic              rd_take;
  logic [NCH*BW-1:0] ch_bytes;
  logic [BW-1:0]     mux_byte;
  logic [BW-1:0]     rdata_q, rdata_d;

  tmr_bus_decode #(.NCH(NCH)) u_dec (
    .cs       (cs),
    .rd       (rd),
    .wr       (wr),
    .addr     (addr),
    .cw_sel   (wdata[7:6]),
    .cw_fmt   (wdata[5:4]),
    .cfg_stb  (cfg_stb),
    .snap_stb (snap_stb),
    .dwr_stb  (dwr_stb),
    .drd_stb  (drd_stb),
    .rd_take  (rd_take)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_chan_port #(.BW(BW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .cfg_stb  (cfg_stb[i]),
      .snap_stb (snap_stb[i]),
      .dwr_stb  (dwr_stb[i]),
      .drd_stb  (drd_stb[i]),
      .wbyte    (wdata),
      .live     (live_cnt[i*CW +: CW]),
      .rd_byte  (ch_bytes[i*BW +: BW]),
      .ld_val   (ld_val[i*CW +: CW]),
      .ld_stb   (ld_stb[i]),
      .mode     (mode_o[i*3 +: 3]),
      .bcd      (bcd_o[i])
    );
  end

  tmr_rd_mux #(.NCH(NCH), .BW(BW)) u_mux (
    .addr     (addr),
    .bytes    (ch_bytes),
    .sel_byte (mux_byte)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (rd_take) rdata_d = mux_byte;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/tmr_bus_chk.sv
module tmr_bus_chk #(
  parameter int NCH = 3,
  parameter int BW  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             rd,
  input logic             wr,
  input logic [1:0]       addr,
  input logic [BW-1:0]    wdata,
  input logic [BW-1:0]    rdata,
  input logic [NCH-1:0]   ld_stb,
  input logic [NCH*3-1:0] mode_o,
  input logic [NCH-1:0]   bcd_o
);

  // R1
  cfg_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'b11 && wdata[7:6] == 2'b00 && wdata[5:4] != 2'b00)
    |=> (mode_o[2:0] == $past(wdata[3:1]) && bcd_o[0] == $past(wdata[0])));

  // R2
  ld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_stb));

  // R4
  ld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb != '0) |-> $past(cs && wr && addr != 2'b11));

  // R10
  ctl_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !wr && addr == 2'b11) |=> (rdata == '0));

  // R11
  rd_wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && wr) |=> $stable(rdata));

endmodule

bind tmr_bus_if tmr_bus_chk #(.NCH(NCH), .BW(BW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_i_n),
  .cs     (cs),
  .rd     (rd),
  .wr     (wr),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .ld_stb (ld_stb),
  .mode_o (mode_o),
  .bcd_o  (bcd_o)
);

// File: tb/sim_tmr_bus_if.sv
module sim_tmr_bus_if;
  localparam int TCLK = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0]  addr = 2'b00;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [47:0] live_cnt = 48'h0;
  logic [47:0] ld_val;
  logic [2:0]  ld_stb;
  logic [8:0]  mode_o;
  logic [2:0]  bcd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  tmr_bus_if u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .ld_val(ld_val),
    .ld_stb(ld_stb), .mode_o(mode_o), .bcd_o(bcd_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cwb(input int sel, input int fmt, input int md, input int b);
    return {2'(sel), 2'(fmt), 3'(md), 1'(b)};
  endfunction

  task automatic set_live(input int ch, input logic [15:0] v);
    live_cnt[ch*16 +: 16] = v;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    chk("R12 mode", 32'(mode_o), 32'h0);
    chk("R12 bcd", 32'(bcd_o), 32'h0);
    chk("R12 ld_stb", 32'(ld_stb), 32'h0);
    chk("R12 rdata", 32'(rdata), 32'h0);
  endtask

  task automatic t_config;
    bus_wr(2'd3, cwb(1, 2, 5, 1));
    chk("R1 mode ch1", 32'(mode_o[5:3]), 32'd5);
    chk("R1 bcd ch1", 32'(bcd_o), 32'b010);
    chk("R1 others", 32'({mode_o[8:6], mode_o[2:0]}), 32'h0);
    bus_wr(2'd3, cwb(3, 1, 7, 1));
    chk("R1 sel3 ignored", 32'({mode_o, bcd_o}), 32'({9'b000_101_000, 3'b010}));
  endtask

  task automatic t_loads;
    bus_wr(2'd3, cwb(0, 1, 0, 0));
    bus_wr(2'd0, 8'h9C);
    chk("R2 stb", 32'(ld_stb), 32'b001);
    chk("R2 val", 32'(ld_val[15:0]), 32'h009C);
    @(negedge clk);
    chk("R2 one cycle", 32'(ld_stb), 32'b000);
    bus_wr(2'd1, 8'h7E);
    chk("R3 stb", 32'(ld_stb), 32'b010);
    chk("R3 val", 32'(ld_val[31:16]), 32'h7E00);
    bus_wr(2'd2, 8'h34);
    chk("R4 first no stb", 32'(ld_stb), 32'b000);
    bus_wr(2'd2, 8'h12);
    chk("R4 stb", 32'(ld_stb), 32'b100);
    chk("R4 val", 32'(ld_val[47:32]), 32'h1234);
  endtask

  task automatic t_reads;
    logic [7:0] b;
    set_live(0, 16'h3C4D); set_live(1, 16'hB1C2); set_live(2, 16'hA55A);
    bus_rd(2'd2, b); chk("R5 both lo", 32'(b), 32'h5A);
    bus_rd(2'd2, b); chk("R5 both hi", 32'(b), 32'hA5);
    bus_rd(2'd2, b); chk("R5 wraps lo", 32'(b), 32'h5A);
    bus_rd(2'd2, b);
    bus_rd(2'd0, b); chk("R5 lo only", 32'(b), 32'h4D);
    bus_rd(2'd1, b); chk("R5 hi only", 32'(b), 32'hB1);
    bus_rd(2'd3, b); chk("R10 ctl read", 32'(b), 32'h00);
    bus_rd(2'd2, b); chk("R10 no ptr move", 32'(b), 32'h5A);
    bus_rd(2'd2, b);
  endtask

  task automatic t_snapshot;
    logic [7:0] b;
    bus_wr(2'd3, cwb(0, 3, 2, 0));
    set_live(0, 16'h1234);
    bus_wr(2'd3, cwb(0, 0, 0, 0));
    set_live(0, 16'h5678);
    bus_wr(2'd3, cwb(0, 0, 0, 0));
    chk("R6 mode kept", 32'(mode_o[2:0]), 32'd2);
    set_live(0, 16'h9ABC);
    bus_rd(2'd0, b); chk("R6 snap lo", 32'(b), 32'h34);
    bus_rd(2'd0, b); chk("R8 repeat ignored", 32'(b), 32'h12);
    bus_rd(2'd0, b); chk("R7 released lo", 32'(b), 32'hBC);
    bus_rd(2'd0, b); chk("R7 released hi", 32'(b), 32'h9A);
    // same-cycle capture and live update on channel 1
    bus_wr(2'd3, cwb(1, 3, 0, 0));
    set_live(1, 16'h1111);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = 2'd3; wdata = cwb(1, 0, 0, 0);
    set_live(1, 16'h4321);
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    set_live(1, 16'h0000);
    @(negedge clk);
    bus_rd(2'd1, b); chk("R6 capture edge lo", 32'(b), 32'h21);
    bus_rd(2'd1, b); chk("R6 capture edge hi", 32'(b), 32'h43);
  endtask

  task automatic t_reprogram;
    logic [7:0] b;
    bus_wr(2'd2, 8'h11);
    bus_wr(2'd3, cwb(2, 3, 2, 0));
    bus_wr(2'd2, 8'h22);
    chk("R9 wptr reset no stb", 32'(ld_stb), 32'b000);
    bus_wr(2'd2, 8'h33);
    chk("R9 wptr reset val", 32'(ld_val[47:32]), 32'h3322);
    set_live(2, 16'hF00D);
    bus_wr(2'd3, cwb(2, 0, 0, 0));
    set_live(2, 16'hBEEF);
    bus_rd(2'd2, b);
    bus_wr(2'd3, cwb(2, 3, 2, 0));
    bus_rd(2'd2, b); chk("R9 rptr and snap reset", 32'(b), 32'hEF);
    bus_rd(2'd2, b); chk("R9 live hi", 32'(b), 32'hBE);
  endtask

  task automatic t_clash;
    logic [7:0] b;
    bus_wr(2'd3, cwb(0, 3, 0, 0));
    set_live(0, 16'hCDEF);
    set_live(1, 16'h6600);
    bus_wr(2'd3, cwb(1, 2, 0, 0));
    bus_rd(2'd1, b);
    cs = 1'b1; rd = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 8'h44;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
    chk("R11 rdata held", 32'(rdata), 32'h66);
    bus_rd(2'd0, b); chk("R11 rptr unmoved", 32'(b), 32'hEF);
    bus_rd(2'd0, b);
    bus_wr(2'd0, 8'h55);
    chk("R11 write acted", 32'(ld_val[15:0]), 32'h5544);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_config();
    t_loads();
    t_reads();
    t_snapshot();
    t_reprogram();
    t_clash();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule